// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block moves processor context between the register file of an 8-bit core and a stack kept in RAM, one byte per memory cycle. On a hardware interrupt or a software trap it stores the 16-bit program counter, the X index register, the accumulator and the condition-code byte. On return from interrupt it reads the same five bytes back in the reverse order and hands each one to the register file. The same engine also runs single-byte push and pop of A, X or CC, a reset of the stack pointer, loading the stack pointer from X or A, and copying the stack pointer into X or A.

The stack pointer is 8 bits wide and lives in this block. It addresses one RAM page, set by a parameter. The stack grows downward. A push writes at the stack pointer and then decrements it. A pop increments the stack pointer and then reads at the new value. The PC goes out low byte first, so a return reads the high byte before the low byte. Register values are captured when a command is accepted. Results leave through one-cycle write strobes.

Commands arrive on a valid/ready pair. `cmd_ready` is high only while the block is idle. Memory traffic uses a request channel with valid and ready. A request beat is complete in a cycle where `mem_req_valid` and `mem_req_ready` are both high. Until then, `mem_req_valid`, the address, the write flag and the write data hold steady. Memory may stall for any number of cycles. For a read, `mem_rdata` must carry the byte in the same cycle as the completing beat.

Top module: `ctx_stack_seq`

## Requirements
- R1: `cmd_ready` equals the inverse of `busy`. A command is taken when `cmd_valid` and `cmd_ready` are both high. `busy` is high from the next cycle. It stays high up to and including the cycle of `done`.
- R2: Op code 0 (interrupt) and op code 1 (trap) both issue five writes. The first goes to {page, SP} and each following write goes one byte lower. The data order is PC[7:0], PC[15:8], X, A, CC. SP ends 5 below its start.
- R3: During entry the byte written for CC is the captured value with nothing changed. In the beat that writes it, `wr_cc` pulses with that value OR'ed with bit MASK_BIT (default 3), which sets the interrupt mask.
- R4: Op code 2 (return) issues five reads at {page, SP+1} up to {page, SP+5}. It strobes `wr_cc`, `wr_a` and `wr_x` in that order with the bytes read. In its last beat it pulses `pc_wr` with {fourth byte, fifth byte}. SP ends 5 above its start.
- R5: Op codes 3, 4 and 5 push A, X and CC. Each writes one byte at {page, SP} and decrements SP. None of them pulses `wr_cc`.
- R6: Op codes 6, 7 and 8 pop A, X and CC. Each reads at {page, SP+1}, increments SP and strobes only the named register. At most one register strobe is high in any cycle.
- R7: `sp_out` is SP_TOP (default 0xFF) after reset. Op code 9 sets it back to SP_TOP.
- R8: Op codes 10 and 11 load SP from the captured X and A. Op codes 12 and 13 strobe `wr_x` and `wr_a`, with `wr_data` set to the current SP.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, address, write flag and data hold. SP does not move and no register strobe fires.
- R10: `done` is a one-cycle pulse. For memory commands it comes in the last completing beat. For register commands it comes in the single cycle after acceptance. Op codes 14 and 15 complete this way with no memory traffic, no strobe and SP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_op | input | 4 | Command op code |
| pc_in | input | 16 | Current program counter, captured at accept |
| x_in | input | 8 | Current X, captured at accept |
| a_in | input | 8 | Current A, captured at accept |
| cc_in | input | 8 | Current condition codes, captured at accept |
| mem_req_valid | output | 1 | Memory beat requested |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the completing beat |
| wr_a | output | 1 | Load A from wr_data |
| wr_x | output | 1 | Load X from wr_data |
| wr_cc | output | 1 | Load CC from wr_data |
| wr_data | output | 8 | Data for the register strobes |
| pc_wr | output | 1 | Load PC from pc_wr_data |
| pc_wr_data | output | 16 | Restored program counter |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Command completes this cycle |

## Verification
A wrong stack pointer shows up as a wrong address on the very next memory beat. After a register command it shows on `sp_out` one cycle later. A step counter that slips puts a byte out of place: a PC half in the X slot, or a restore strobe out of order. It can also move `done` earlier or later than the fifth beat. The bench places every byte it expects, so a slip is caught inside the same command. Stall cycles are inserted on the memory channel to show that a held beat neither moves SP nor fires a strobe before it completes.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [3:0] {
    OP_IRQ      = 4'd0,
    OP_TRAP     = 4'd1,
    OP_IRET     = 4'd2,
    OP_PUSH_A   = 4'd3,
    OP_PUSH_X   = 4'd4,
    OP_PUSH_CC  = 4'd5,
    OP_POP_A    = 4'd6,
    OP_POP_X    = 4'd7,
    OP_POP_CC   = 4'd8,
    OP_SP_RST   = 4'd9,
    OP_SP_FRM_X = 4'd10,
    OP_SP_FRM_A = 4'd11,
    OP_SP_TO_X  = 4'd12,
    OP_SP_TO_A  = 4'd13,
    OP_NOP_E    = 4'd14,
    OP_NOP_F    = 4'd15
  } ctx_op_e;

  typedef enum logic [2:0] {
    SL_PCL, SL_PCH, SL_X, SL_A, SL_CC, SL_NONE
  } slot_e;

  typedef enum logic [2:0] {
    SP_HOLD, SP_DEC, SP_INC, SP_LOAD, SP_RESET
  } sp_act_e;

  localparam int STEP_W = 3;

  function automatic logic [STEP_W-1:0] seq_len(input ctx_op_e op);
    case (op)
      OP_IRQ, OP_TRAP, OP_IRET: return 3'd5;
      OP_PUSH_A, OP_PUSH_X, OP_PUSH_CC,
      OP_POP_A, OP_POP_X, OP_POP_CC: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic is_pop(input ctx_op_e op);
    return (op == OP_IRET) || (op == OP_POP_A) || (op == OP_POP_X) || (op == OP_POP_CC);
  endfunction

  function automatic logic is_entry(input ctx_op_e op);
    return (op == OP_IRQ) || (op == OP_TRAP);
  endfunction

  // Byte carried by step idx of a memory sequence
  function automatic slot_e slot_at(input ctx_op_e op, input logic [STEP_W-1:0] idx);
    case (op)
      OP_IRQ, OP_TRAP:
        case (idx)
          3'd0: return SL_PCL;
          3'd1: return SL_PCH;
          3'd2: return SL_X;
          3'd3: return SL_A;
          default: return SL_CC;
        endcase
      OP_IRET:
        case (idx)
          3'd0: return SL_CC;
          3'd1: return SL_A;
          3'd2: return SL_X;
          3'd3: return SL_PCH;
          default: return SL_PCL;
        endcase
      OP_PUSH_A, OP_POP_A:   return SL_A;
      OP_PUSH_X, OP_POP_X:   return SL_X;
      OP_PUSH_CC, OP_POP_CC: return SL_CC;
      default: return SL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg
  import ctx_pkg::*;
#(
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  sp_act_e         act,
  input  logic [SP_W-1:0] ld_val,
  output logic [SP_W-1:0] sp
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= SP_TOP;
    end else begin
      case (act)
        SP_DEC:   sp <= sp - 1'b1;
        SP_INC:   sp <= sp + 1'b1;
        SP_LOAD:  sp <= ld_val;
        SP_RESET: sp <= SP_TOP;
        default:  sp <= sp;
      endcase
    end
  end

  p_sp_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act == SP_RESET |=> sp == SP_TOP);

  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act == SP_HOLD |=> $stable(sp));

  p_sp_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act == SP_DEC |=> (sp + 1'b1) == $past(sp));

endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
  import ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  output logic              cmd_ready,
  output logic              accept,
  input  logic              mem_hs,
  output ctx_op_e           op_q,
  output logic [STEP_W-1:0] idx_q,
  output logic              mem_phase,
  output logic              reg_exec,
  output logic              busy,
  output logic              done
);

  logic              busy_q;
  logic [STEP_W-1:0] len;
  logic              last;

  assign len       = seq_len(op_q);
  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign mem_phase = busy_q && (len != '0);
  assign reg_exec  = busy_q && (len == '0);
  assign last      = (idx_q == len - 1'b1);
  assign done      = reg_exec || (mem_phase && mem_hs && last);
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NOP_F;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= ctx_op_e'(cmd_op);
      idx_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (mem_phase && mem_hs) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  p_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  p_stay_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

endmodule

// File: rtl/ctx_datapath.sv
module ctx_datapath
  import ctx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int SP_W     = 8,
  parameter int MASK_BIT = 3,
  parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   cc_in,
  input  ctx_op_e             op_q,
  input  logic [STEP_W-1:0]   idx_q,
  input  logic                mem_phase,
  input  logic                reg_exec,
  input  logic                mem_ready,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic [SP_W-1:0]     sp,
  output logic                mem_write,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output sp_act_e             sp_act,
  output logic [SP_W-1:0]     sp_ld,
  output logic                wr_a,
  output logic                wr_x,
  output logic                wr_cc,
  output logic [DATA_W-1:0]   wr_data,
  output logic                pc_wr,
  output logic [2*DATA_W-1:0] pc_wr_data
);

  logic [2*DATA_W-1:0] pc_q;
  logic [DATA_W-1:0]   x_q, a_q, cc_q, pch_q, cc_masked;
  logic [SP_W-1:0]     sp_up;
  logic                pop, hs;
  slot_e               slot;

  assign slot      = slot_at(op_q, idx_q);
  assign pop       = is_pop(op_q);
  assign hs        = mem_phase && mem_ready;
  assign sp_up     = sp + 1'b1;
  assign cc_masked = cc_q | (DATA_W'(1) << MASK_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      x_q   <= '0;
      a_q   <= '0;
      cc_q  <= '0;
      pch_q <= '0;
    end else begin
      if (accept) begin
        pc_q <= pc_in;
        x_q  <= x_in;
        a_q  <= a_in;
        cc_q <= cc_in;
      end
      if (hs && pop && slot == SL_PCH) pch_q <= mem_rdata;
    end
  end

  // Memory beat formation
  assign mem_write = !pop;
  assign mem_addr  = {STACK_PAGE, (pop ? sp_up : sp)};

  always_comb begin
    case (slot)
      SL_PCL:  mem_wdata = pc_q[DATA_W-1:0];
      SL_PCH:  mem_wdata = pc_q[2*DATA_W-1:DATA_W];
      SL_X:    mem_wdata = x_q;
      SL_A:    mem_wdata = a_q;
      SL_CC:   mem_wdata = cc_q;
      default: mem_wdata = '0;
    endcase
  end

  // Stack pointer movement
  always_comb begin
    sp_act = SP_HOLD;
    sp_ld  = (op_q == OP_SP_FRM_X) ? x_q : a_q;
    if (hs) begin
      sp_act = pop ? SP_INC : SP_DEC;
    end else if (reg_exec) begin
      case (op_q)
        OP_SP_RST:                sp_act = SP_RESET;
        OP_SP_FRM_X, OP_SP_FRM_A: sp_act = SP_LOAD;
        default:                  sp_act = SP_HOLD;
      endcase
    end
  end

  // Register write strobes
  always_comb begin
    wr_a    = 1'b0;
    wr_x    = 1'b0;
    wr_cc   = 1'b0;
    pc_wr   = 1'b0;
    wr_data = '0;
    if (hs && pop) begin
      wr_data = mem_rdata;
      case (slot)
        SL_A:    wr_a  = 1'b1;
        SL_X:    wr_x  = 1'b1;
        SL_CC:   wr_cc = 1'b1;
        SL_PCL:  pc_wr = 1'b1;
        default: ;
      endcase
    end else if (hs && is_entry(op_q) && slot == SL_CC) begin
      wr_cc   = 1'b1;
      wr_data = cc_masked;
    end else if (reg_exec) begin
      wr_data = sp;
      wr_x    = (op_q == OP_SP_TO_X);
      wr_a    = (op_q == OP_SP_TO_A);
    end
  end

  assign pc_wr_data = {pch_q, mem_rdata};

  p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_phase && !mem_ready |=> mem_phase && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_write));

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_a, wr_x, wr_cc, pc_wr}));

  p_push_no_cc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_PUSH_A || op_q == OP_PUSH_X || op_q == OP_PUSH_CC) |-> !wr_cc);

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int SP_W     = 8,
  parameter int MASK_BIT = 3,
  parameter logic [ADDR_W-SP_W-1:0] STACK_PAGE = 1,
  parameter logic [SP_W-1:0]        SP_TOP     = {SP_W{1'b1}}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [3:0]          cmd_op,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   cc_in,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                wr_a,
  output logic                wr_x,
  output logic                wr_cc,
  output logic [DATA_W-1:0]   wr_data,
  output logic                pc_wr,
  output logic [2*DATA_W-1:0] pc_wr_data,
  output logic [SP_W-1:0]     sp_out,
  output logic                busy,
  output logic                done
);

  ctx_op_e           op_q;
  logic [STEP_W-1:0] idx_q;
  logic              accept, mem_phase, reg_exec, mem_hs;
  sp_act_e           sp_act;
  logic [SP_W-1:0]   sp_ld;

  assign mem_req_valid = mem_phase;
  assign mem_hs        = mem_phase && mem_req_ready;

  ctx_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .mem_hs    (mem_hs),
    .op_q      (op_q),
    .idx_q     (idx_q),
    .mem_phase (mem_phase),
    .reg_exec  (reg_exec),
    .busy      (busy),
    .done      (done)
  );

  ctx_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SP_W       (SP_W),
    .MASK_BIT   (MASK_BIT),
    .STACK_PAGE (STACK_PAGE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .pc_in      (pc_in),
    .x_in       (x_in),
    .a_in       (a_in),
    .cc_in      (cc_in),
    .op_q       (op_q),
    .idx_q      (idx_q),
    .mem_phase  (mem_phase),
    .reg_exec   (reg_exec),
    .mem_ready  (mem_req_ready),
    .mem_rdata  (mem_rdata),
    .sp         (sp_out),
    .mem_write  (mem_req_write),
    .mem_addr   (mem_req_addr),
    .mem_wdata  (mem_req_wdata),
    .sp_act     (sp_act),
    .sp_ld      (sp_ld),
    .wr_a       (wr_a),
    .wr_x       (wr_x),
    .wr_cc      (wr_cc),
    .wr_data    (wr_data),
    .pc_wr      (pc_wr),
    .pc_wr_data (pc_wr_data)
  );

  ctx_sp_reg #(
    .SP_W   (SP_W),
    .SP_TOP (SP_TOP)
  ) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (sp_act),
    .ld_val (sp_ld),
    .sp     (sp_out)
  );

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(sp_out));

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

endmodule

// File: tb/tb_ctx_stack_seq.sv
`timescale 1ns/1ps
module tb_ctx_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = 4'd0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, a_in = '0, cc_in = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1;
  logic [15:0] mem_req_addr;
  logic [7:0]  mem_req_wdata, mem_rdata;
  logic        wr_a, wr_x, wr_cc, pc_wr, busy, done;
  logic [7:0]  wr_data, sp_out;
  logic [15:0] pc_wr_data;

  always #2 clk = ~clk;

  ctx_stack_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
    .wr_a(wr_a), .wr_x(wr_x), .wr_cc(wr_cc), .wr_data(wr_data),
    .pc_wr(pc_wr), .pc_wr_data(pc_wr_data), .sp_out(sp_out),
    .busy(busy), .done(done)
  );

  // Stack memory model and event logs
  logic [7:0]  mem [0:255];
  logic [15:0] lg_addr [0:15];
  logic        lg_wr   [0:15];
  logic [7:0]  lg_dat  [0:15];
  logic [2:0]  wb_kind [0:15];
  logic [15:0] wb_val  [0:15];
  int          lg_n, wb_n, done_n, stall_bad;
  logic        log_clr = 1'b0;
  logic        stall_en = 1'b0;
  logic        prev_stall;
  logic [15:0] prev_addr;
  logic [7:0]  prev_wd, prev_sp;
  logic        prev_w;

  assign mem_rdata = mem[mem_req_addr[7:0]];

  always @(negedge clk) mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready && mem_req_write)
      mem[mem_req_addr[7:0]] <= mem_req_wdata;
    if (log_clr) begin
      lg_n <= 0; wb_n <= 0; done_n <= 0; stall_bad <= 0;
    end else begin
      if (mem_req_valid && mem_req_ready && lg_n < 16) begin
        lg_addr[lg_n] <= mem_req_addr;
        lg_wr[lg_n]   <= mem_req_write;
        lg_dat[lg_n]  <= mem_req_write ? mem_req_wdata : mem_rdata;
        lg_n <= lg_n + 1;
      end
      if ((wr_a || wr_x || wr_cc || pc_wr) && wb_n < 16) begin
        wb_kind[wb_n] <= wr_a ? 3'd1 : wr_x ? 3'd2 : wr_cc ? 3'd3 : 3'd4;
        wb_val[wb_n]  <= pc_wr ? pc_wr_data : {8'h00, wr_data};
        wb_n <= wb_n + 1;
      end
      if (mem_req_valid && !mem_req_ready && (wr_a || wr_x || wr_cc || pc_wr))
        stall_bad <= stall_bad + 1;
      if (done) done_n <= done_n + 1;
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr ||
          mem_req_wdata != prev_wd || mem_req_write != prev_w || sp_out != prev_sp))
        stall_bad <= stall_bad + 1;
    end
    prev_stall <= mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_req_addr;
    prev_wd    <= mem_req_wdata;
    prev_w     <= mem_req_write;
    prev_sp    <= sp_out;
  end

  int n_total = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  task automatic run_op(input logic [3:0] op);
    int k;
    clear_logs();
    cmd_op = op;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R1 busy after accept", {busy, cmd_ready}, 2'b10);
    k = 0;
    while (busy && k < 300) begin
      @(negedge clk);
      k++;
    end
    check("R1 returns idle", {busy, cmd_ready}, 2'b01);
    check("R10 one done", done_n, 1);
  endtask

  task automatic chk_beat(input string req, input int i, input logic [15:0] addr,
                          input logic w, input logic [7:0] d);
    check(req, {lg_addr[i], 7'd0, lg_wr[i], lg_dat[i]}, {addr, 7'd0, w, d});
  endtask

  task automatic chk_wb(input string req, input int i, input logic [2:0] kind,
                        input logic [15:0] v);
    check(req, {13'd0, wb_kind[i], wb_val[i]}, {13'd0, kind, v});
  endtask

  task automatic t_reset();
    check("R7 reset sp", sp_out, 8'hFF);
    check("R1 reset idle", {busy, cmd_ready, mem_req_valid, done}, 4'b0100);
  endtask

  task automatic t_sp_from_a();
    a_in = 8'h80;
    run_op(4'd11);
    check("R8 sp from A", sp_out, 8'h80);
    check("R8 no traffic", lg_n, 0);
  endtask

  task automatic t_irq_entry();
    pc_in = 16'h1234; x_in = 8'h56; a_in = 8'h78; cc_in = 8'h21;
    run_op(4'd0);
    check("R2 beats", lg_n, 5);
    chk_beat("R2 pcl", 0, 16'h0180, 1'b1, 8'h34);
    chk_beat("R2 pch", 1, 16'h017F, 1'b1, 8'h12);
    chk_beat("R2 x",   2, 16'h017E, 1'b1, 8'h56);
    chk_beat("R2 a",   3, 16'h017D, 1'b1, 8'h78);
    chk_beat("R3 cc stored unmasked", 4, 16'h017C, 1'b1, 8'h21);
    check("R3 one cc strobe", wb_n, 1);
    chk_wb("R3 masked cc", 0, 3'd3, 16'h0029);
    check("R2 sp end", sp_out, 8'h7B);
  endtask

  task automatic t_iret_stalled();
    stall_en = 1'b1;
    run_op(4'd2);
    stall_en = 1'b0;
    check("R4 beats", lg_n, 5);
    chk_beat("R4 rd cc",  0, 16'h017C, 1'b0, 8'h21);
    chk_beat("R4 rd a",   1, 16'h017D, 1'b0, 8'h78);
    chk_beat("R4 rd x",   2, 16'h017E, 1'b0, 8'h56);
    chk_beat("R4 rd pch", 3, 16'h017F, 1'b0, 8'h12);
    chk_beat("R4 rd pcl", 4, 16'h0180, 1'b0, 8'h34);
    check("R4 strobes", wb_n, 4);
    chk_wb("R4 cc first", 0, 3'd3, 16'h0021);
    chk_wb("R4 a second", 1, 3'd1, 16'h0078);
    chk_wb("R4 x third",  2, 3'd2, 16'h0056);
    chk_wb("R4 pc last",  3, 3'd4, 16'h1234);
    check("R4 sp end", sp_out, 8'h80);
    check("R9 stall hold", stall_bad, 0);
  endtask

  task automatic t_trap_stalled();
    pc_in = 16'hBEEF; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h00;
    stall_en = 1'b1;
    run_op(4'd1);
    stall_en = 1'b0;
    check("R2 trap beats", lg_n, 5);
    chk_beat("R2 trap pcl", 0, 16'h0180, 1'b1, 8'hEF);
    chk_beat("R2 trap pch", 1, 16'h017F, 1'b1, 8'hBE);
    chk_beat("R2 trap cc",  4, 16'h017C, 1'b1, 8'h00);
    chk_wb("R3 trap mask", 0, 3'd3, 16'h0008);
    check("R2 trap sp", sp_out, 8'h7B);
    check("R9 trap stall hold", stall_bad, 0);
  endtask

  task automatic t_push_pop_x_a();
    x_in = 8'h9A;
    run_op(4'd4);
    check("R5 push beats", lg_n, 1);
    chk_beat("R5 push x", 0, 16'h017B, 1'b1, 8'h9A);
    check("R5 no cc strobe", wb_n, 0);
    check("R5 sp dec", sp_out, 8'h7A);
    run_op(4'd6);
    chk_beat("R6 pop a", 0, 16'h017B, 1'b0, 8'h9A);
    check("R6 single strobe", wb_n, 1);
    chk_wb("R6 a loaded", 0, 3'd1, 16'h009A);
    check("R6 sp inc", sp_out, 8'h7B);
  endtask

  task automatic t_push_pop_cc();
    cc_in = 8'h5C;
    run_op(4'd5);
    chk_beat("R5 push cc", 0, 16'h017B, 1'b1, 8'h5C);
    check("R5 push cc no strobe", wb_n, 0);
    cc_in = 8'h00;
    run_op(4'd8);
    chk_wb("R6 pop cc", 0, 3'd3, 16'h005C);
    check("R6 pop cc count", wb_n, 1);
  endtask

  task automatic t_sp_regs();
    run_op(4'd12);
    chk_wb("R8 sp to x", 0, 3'd2, 16'h007B);
    run_op(4'd13);
    chk_wb("R8 sp to a", 0, 3'd1, 16'h007B);
    run_op(4'd9);
    check("R7 sp reset op", sp_out, 8'hFF);
    x_in = 8'h40;
    run_op(4'd10);
    check("R8 sp from x", sp_out, 8'h40);
  endtask

  task automatic t_unused();
    run_op(4'd14);
    check("R10 unused sp", sp_out, 8'h40);
    check("R10 unused quiet", {lg_n[7:0], wb_n[7:0]}, 16'h0000);
    run_op(4'd15);
    check("R10 unused f quiet", {sp_out, lg_n[7:0], wb_n[7:0]}, 24'h400000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sp_from_a();
    t_irq_entry();
    t_iret_stalled();
    t_trap_stalled();
    t_push_pop_x_a();
    t_push_pop_cc();
    t_sp_regs();
    t_unused();
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule